// File: doc/BRIEF.md
# Tag Password and Kill Gate

This block keeps the two 32-bit secrets of a passive tag, the access password and the kill password, and decides what happens when a reader presents a candidate value. Each secret is held as two 16-bit words, loaded through a small word write port. The block reports the tag state: open, secured or killed. A silent flag is raised once the tag is dead.

An access attempt moves an open tag to secured when the candidate matches the stored access password. If the stored access password is zero, any attempt succeeds and no check is made. A kill attempt makes the tag permanently silent when the candidate matches a non-zero kill password. A zero kill password disables killing entirely.

A failed attempt raises a one-cycle error pulse. The killed condition survives the ordinary reset. Only the separate non-volatile reset clears it, and that reset also returns both passwords to zero.

Top module: `tag_pw_gate`

## Requirements
- R1: After reset the state output is open (2'b00), the silent flag is 0 and the error output is 0.
- R2: Word address 0 holds kill bits 31:16 and address 1 holds kill bits 15:0. Address 2 holds access bits 31:16 and address 3 holds access bits 15:0. Candidate bit 31 is compared with the top bit of the high word. A write takes effect for an attempt made in the following cycle.
- R3: While the access password is zero, an access attempt sets the state to secured (2'b01) with no error, whatever the candidate.
- R4: While the access password is non-zero, a matching access attempt gives secured. A mismatching attempt gives open and a one-cycle error pulse.
- R5: A kill attempt while the kill password is zero is refused even for a zero candidate. The block pulses the error output and leaves the state unchanged.
- R6: A kill attempt that matches a non-zero kill password gives state killed (2'b10) and silent 1. A mismatch pulses the error output and leaves the state unchanged.
- R7: Once killed, access attempts, kill attempts and password writes have no effect. The state stays killed and the error output stays 0.
- R8: The killed state persists across the ordinary reset. The non-volatile reset returns the block to open with both passwords zero.
- R9: When kill and access attempts arrive in the same cycle, only the kill attempt is evaluated.
- R10: The ordinary reset returns a secured tag to open and keeps the stored passwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary asynchronous active-low reset |
| nv_rst_n | input | 1 | Non-volatile asynchronous active-low reset |
| wr_en | input | 1 | Password word write strobe |
| wr_addr | input | 2 | Password word address |
| wr_data | input | 16 | Password word data |
| acc_try | input | 1 | Access attempt strobe |
| kill_try | input | 1 | Kill attempt strobe |
| cand | input | 32 | Candidate password |
| state_o | output | 2 | 00 open, 01 secured, 10 killed |
| silent_o | output | 1 | Tag is silent (killed) |
| err_o | output | 1 | One-cycle pulse on a refused attempt |

## Verification
Every result is registered. A strobe or write sampled at one rising edge shows on the state, silent and error outputs, or in the stored passwords, right after that same edge. The bench drives inputs on the falling edge and checks outputs on the next falling edge. It then checks once more one cycle later to confirm that the error pulse has ended. After each reset is released, two synchronizer cycles pass before the block responds, so the bench waits several cycles before its first stimulus.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int WORD_W    = 16;
  localparam int PW_WORDS  = 2;
  localparam int PW_W      = WORD_W * PW_WORDS;
  localparam int N_WORDS   = 2 * PW_WORDS;
  localparam int ADDR_W    = $clog2(N_WORDS);

  typedef enum logic [1:0] {
    ST_OPEN    = 2'b00,
    ST_SECURED = 2'b01,
    ST_KILLED  = 2'b10
  } tag_state_e;
endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tpg_pw_store.sv
module tpg_pw_store
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              nv_rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [PW_W-1:0]   kill_pw,
  output logic [PW_W-1:0]   acc_pw
);
  logic [N_WORDS-1:0][WORD_W-1:0] words_q;
  logic [N_WORDS-1:0]             word_en;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    assign word_en[g] = wr_en && !lock && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge nv_rst_n) begin
      if (!nv_rst_n)       words_q[g] <= '0;
      else if (word_en[g]) words_q[g] <= wr_data;
    end
  end

  // low addresses hold the kill secret, high word first
  for (genvar h = 0; h < PW_WORDS; h++) begin : g_map
    assign kill_pw[PW_W-1-h*WORD_W -: WORD_W] = words_q[h];
    assign acc_pw [PW_W-1-h*WORD_W -: WORD_W] = words_q[PW_WORDS+h];
  end

  // R7: a killed tag keeps its secrets unchanged
  a_r7_store_locked: assert property (@(posedge clk) disable iff (!nv_rst_n)
    lock |=> $stable(words_q));
  // R2: a write lands in the addressed word
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!nv_rst_n)
    (wr_en && !lock && wr_addr == '0) |=> (words_q[0] == $past(wr_data)));
endmodule

// File: rtl/tpg_pw_cmp.sv
module tpg_pw_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] stored,
  output logic         match,
  output logic         zero
);
  assign match = (cand == stored);
  assign zero  = (stored == '0);
endmodule

// File: rtl/tpg_fsm.sv
module tpg_fsm
  import tpg_pkg::*;
(
  input  logic       clk,
  input  logic       core_rst_n,
  input  logic       nv_rst_n,
  input  logic       acc_try,
  input  logic       kill_try,
  input  logic       acc_match,
  input  logic       acc_zero,
  input  logic       kill_match,
  input  logic       kill_zero,
  output tag_state_e state,
  output logic       killed,
  output logic       err
);
  logic sec_q, sec_d;
  logic kill_q, kill_d;
  logic err_q, err_d;

  always_comb begin
    sec_d  = sec_q;
    kill_d = kill_q;
    err_d  = 1'b0;
    if (!kill_q) begin
      if (kill_try) begin
        if (!kill_zero && kill_match) kill_d = 1'b1;
        else                          err_d  = 1'b1;
      end else if (acc_try) begin
        if (acc_zero || acc_match) sec_d = 1'b1;
        else begin
          sec_d = 1'b0;
          err_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sec_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      sec_q <= sec_d;
      err_q <= err_d;
    end
  end

  // kill latch answers only to the non-volatile reset
  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n) kill_q <= 1'b0;
    else           kill_q <= kill_d;
  end

  assign state  = kill_q ? ST_KILLED : (sec_q ? ST_SECURED : ST_OPEN);
  assign killed = kill_q;
  assign err    = err_q;

  // R8: once killed, stays killed
  a_r8_kill_sticky: assert property (@(posedge clk) disable iff (!nv_rst_n)
    kill_q |=> kill_q);
  // R5: zero kill password never kills
  a_r5_zero_kill_refused: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!kill_q && kill_try && kill_zero) |=> (!kill_q && err_q));
  // R7: no error from a dead tag
  a_r7_killed_quiet: assert property (@(posedge clk) disable iff (!core_rst_n)
    kill_q |=> !err_q);
  // R3: zero access password secures
  a_r3_zero_access: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!kill_q && acc_try && !kill_try && acc_zero) |=> (sec_q && !err_q));
  // R4: error only follows an attempt
  a_r4_err_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
    err_q |-> $past(acc_try || kill_try));
  // R9: a kill attempt leaves the secured flag alone
  a_r9_kill_priority: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!kill_q && kill_try) |=> (sec_q == $past(sec_q)));
endmodule

// File: rtl/tag_pw_gate.sv
module tag_pw_gate
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              acc_try,
  input  logic              kill_try,
  input  logic [PW_W-1:0]   cand,
  output logic [1:0]        state_o,
  output logic              silent_o,
  output logic              err_o
);
  logic            core_rst_n, nv_srst_n;
  logic [PW_W-1:0] kill_pw, acc_pw;
  logic            acc_match, acc_zero, kill_match, kill_zero;
  logic            killed;
  tag_state_e      state;

  tpg_rst_sync #(.STAGES(2)) u_core_sync (
    .clk(clk), .arst_n(rst_n & nv_rst_n), .srst_n(core_rst_n));
  tpg_rst_sync #(.STAGES(2)) u_nv_sync (
    .clk(clk), .arst_n(nv_rst_n), .srst_n(nv_srst_n));

  tpg_pw_store u_store (
    .clk(clk), .nv_rst_n(nv_srst_n), .lock(killed),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .kill_pw(kill_pw), .acc_pw(acc_pw));

  tpg_pw_cmp #(.W(PW_W)) u_acc_cmp (
    .cand(cand), .stored(acc_pw), .match(acc_match), .zero(acc_zero));
  tpg_pw_cmp #(.W(PW_W)) u_kill_cmp (
    .cand(cand), .stored(kill_pw), .match(kill_match), .zero(kill_zero));

  tpg_fsm u_fsm (
    .clk(clk), .core_rst_n(core_rst_n), .nv_rst_n(nv_srst_n),
    .acc_try(acc_try), .kill_try(kill_try),
    .acc_match(acc_match), .acc_zero(acc_zero),
    .kill_match(kill_match), .kill_zero(kill_zero),
    .state(state), .killed(killed), .err(err_o));

  assign state_o  = state;
  assign silent_o = killed;

  // R6: silent flag and killed code agree
  a_r6_silent_state: assert property (@(posedge clk) disable iff (!core_rst_n)
    silent_o == (state_o == 2'b10));
endmodule

// File: tb/tag_pw_gate_bench.sv
module tag_pw_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n, nv_rst_n;
  logic        wr_en, acc_try, kill_try;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [31:0] cand;
  logic [1:0]  state_o;
  logic        silent_o, err_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  tag_pw_gate u_tag_pw_gate (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_try(acc_try), .kill_try(kill_try), .cand(cand),
    .state_o(state_o), .silent_o(silent_o), .err_o(err_o));

  // op: 0 idle, 1 write, 2 access, 3 kill, 4 both
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [31:0] cnd;
    logic [1:0]  st;
    logic        er;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 2'd2, 16'h1234, 32'h0,        2'b00, 1'b0, 4'd2},
    '{3'd1, 2'd3, 16'h5678, 32'h0,        2'b00, 1'b0, 4'd2},
    '{3'd2, 2'd0, 16'h0,    32'h12345679, 2'b00, 1'b1, 4'd4},
    '{3'd0, 2'd0, 16'h0,    32'h0,        2'b00, 1'b0, 4'd4},
    '{3'd2, 2'd0, 16'h0,    32'h56781234, 2'b00, 1'b1, 4'd2},
    '{3'd2, 2'd0, 16'h0,    32'h12345678, 2'b01, 1'b0, 4'd4},
    '{3'd3, 2'd0, 16'h0,    32'h0,        2'b01, 1'b1, 4'd5},
    '{3'd1, 2'd0, 16'hDEAD, 32'h0,        2'b01, 1'b0, 4'd2},
    '{3'd1, 2'd1, 16'hBEEF, 32'h0,        2'b01, 1'b0, 4'd2},
    '{3'd3, 2'd0, 16'h0,    32'hDEADBEEE, 2'b01, 1'b1, 4'd6},
    '{3'd2, 2'd0, 16'h0,    32'h0,        2'b00, 1'b1, 4'd4},
    '{3'd4, 2'd0, 16'h0,    32'h12345678, 2'b00, 1'b1, 4'd9},
    '{3'd3, 2'd0, 16'h0,    32'hDEADBEEF, 2'b10, 1'b0, 4'd6},
    '{3'd2, 2'd0, 16'h0,    32'h12345678, 2'b10, 1'b0, 4'd7},
    '{3'd1, 2'd0, 16'h0000, 32'h0,        2'b10, 1'b0, 4'd7},
    '{3'd3, 2'd0, 16'h0,    32'hDEADBEEF, 2'b10, 1'b0, 4'd7}
  };

  task automatic check(input string req, input logic [1:0] st, input logic er);
    n_run++;
    if (state_o !== st || err_o !== er || silent_o !== (st == 2'b10)) begin
      n_fail++;
      $display("FAIL %s: state=%b err=%b silent=%b expected state=%b err=%b silent=%b",
               req, state_o, err_o, silent_o, st, er, st == 2'b10);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] a,
                       input logic [15:0] d, input logic [31:0] c);
    wr_en    = (op == 3'd1);
    acc_try  = (op == 3'd2) || (op == 3'd4);
    kill_try = (op == 3'd3) || (op == 3'd4);
    wr_addr  = a;
    wr_data  = d;
    cand     = c;
    @(negedge clk);
    wr_en = 1'b0; acc_try = 1'b0; kill_try = 1'b0;
  endtask

  task automatic pulse_rst(input bit nv);
    if (nv) nv_rst_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    nv_rst_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; nv_rst_n = 1'b0;
    wr_en = 1'b0; acc_try = 1'b0; kill_try = 1'b0;
    wr_addr = '0; wr_data = '0; cand = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; nv_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 2'b00, 1'b0);

    apply(3'd2, 2'd0, 16'h0, 32'hFFFF_0001);
    check("R3", 2'b01, 1'b0);
    pulse_rst(1'b0);
    check("R10", 2'b00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].cnd);
      check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].st, VECS[i].er);
    end

    pulse_rst(1'b0);
    check("R8", 2'b10, 1'b0);
    pulse_rst(1'b1);
    check("R8", 2'b00, 1'b0);
    apply(3'd2, 2'd0, 16'h0, 32'hA5A5_A5A5);
    check("R8", 2'b01, 1'b0);
    apply(3'd3, 2'd0, 16'h0, 32'h0);
    check("R5", 2'b01, 1'b1);
    apply(3'd0, 2'd0, 16'h0, 32'h0);
    check("R5", 2'b01, 1'b0);

    // R10: passwords kept over ordinary reset
    apply(3'd1, 2'd3, 16'h0001, 32'h0);
    pulse_rst(1'b0);
    check("R10", 2'b00, 1'b0);
    apply(3'd2, 2'd0, 16'h0, 32'h0);
    check("R10", 2'b00, 1'b1);
    apply(3'd2, 2'd0, 16'h0, 32'h0000_0001);
    check("R10", 2'b01, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule